// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block runs a last-in first-out stack of 16-bit words kept in a byte-wide synchronous memory. It holds a 16-bit stack base (segment) register and a 16-bit stack offset register. The byte address it drives is the base times sixteen plus the offset, taken modulo 2^20. Software or a surrounding controller loads the base and the starting offset while the block is idle. An empty stack has the offset set to the byte just past the top of its region. For example, base 58A1h with starting offset 0100h gives a 256-byte region that covers bytes 58A10h through 58B0Fh.

A push first lowers the offset by two and then stores the word as two byte writes, low byte first. A pop reads the two bytes at base:offset, low byte first, and then raises the offset by two. It presents the assembled word with a one-cycle valid strobe. While a word transfer is in progress, the busy output is high and all requests, including loads, are ignored.

Top module: `wstack_engine`

## Requirements
- R1: While rst_n is low, seg_o and sp_o read 0000h, and busy, pop_valid, mem_we and mem_re are all 0.
- R2: In an idle cycle with ld_en high, seg_o takes ld_seg and sp_o takes ld_sp at the next clock edge.
- R3: A transfer at offset P uses byte address (seg_o*16 + P) for the low byte and that address plus 1 for the high byte.
- R4: Bits 7:0 of a word go to or come from the lower byte address and bits 15:8 the next one. The low byte is always transferred first, in consecutive cycles, and mem_we and mem_re are never high together.
- R5: A push lowers sp_o by 2 at the accepting edge, and the word is then written at the lowered offset.
- R6: A pop reads at the current offset, and sp_o rises by 2 in the same cycle that pop_valid is high.
- R7: Pops return words in the reverse of their push order (push 1234h then 5678h, and the first pop gives 5678h).
- R8: While busy is high, push_req, pop_req and ld_en are ignored, and seg_o stays stable.
- R9: Offset arithmetic wraps modulo 2^16, so a push at offset 0000h leaves sp_o at FFFEh.
- R10: The byte address wraps modulo 2^20. With base FFFFh and offset 001Eh, the low byte goes to 0000Eh.
- R11: With requests present together in an idle cycle, a load takes priority over a push, and a push takes priority over a pop.
- R12: A push keeps busy high for exactly 2 cycles, both with mem_we high. A pop keeps busy high for exactly 3 cycles. pop_valid is a single-cycle pulse in the cycle just after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load base and offset (taken only when idle) |
| ld_seg | input | 16 | Base value to load |
| ld_sp | input | 16 | Offset value to load |
| push_req | input | 1 | Push request (taken only when idle) |
| push_word | input | 16 | Word to push, sampled on the accepting edge |
| pop_req | input | 1 | Pop request (taken only when idle) |
| busy | output | 1 | A word transfer is in progress |
| pop_word | output | 16 | Popped word |
| pop_valid | output | 1 | One-cycle strobe qualifying pop_word |
| mem_addr | output | 20 | Byte address to memory |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe; data is returned on the following cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after mem_re |
| seg_o | output | 16 | Current base register |
| sp_o | output | 16 | Current offset register |

## Verification
The assertions assume that the memory returns read data exactly one cycle after mem_re. They also assume that request inputs are settled before each rising edge. The bench memory model provides the one-cycle read, and the bench drives every input only on falling edges. Requests are raised only in idle cycles, except in the scenario that holds all three requests high through a busy window on purpose. That scenario drops them on the falling edge where busy is first seen low, so no stray request reaches an idle edge.

// File: rtl/wstack_pkg.sv
package wstack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR      = 2'd1,
    ST_RD      = 2'd2,
    ST_RD_TAIL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wstack_addr.sv
module wstack_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int CNT_W  = 1,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  lane,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] off_w;
  logic [ADDR_W-1:0] lane_w;

  always_comb begin
    base_w = ADDR_W'({seg, {SHIFT{1'b0}}});
    off_w  = ADDR_W'(off);
    lane_w = ADDR_W'(lane);
    // sum truncates to ADDR_W: modulo 2^ADDR_W wrap (R10)
    phys   = base_w + off_w + lane_w;
  end
endmodule

// File: rtl/wstack_regs.sv
module wstack_regs #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_fire,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [OFF_W-1:0] ld_sp,
  input  logic             dec_fire,
  input  logic             inc_fire,
  output logic [SEG_W-1:0] seg_q,
  output logic [OFF_W-1:0] sp_q
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  logic [SEG_W-1:0] seg_d;
  logic [OFF_W-1:0] sp_d;
  logic             seg_en;
  logic             sp_en;

  always_comb begin
    seg_d  = seg_q;
    sp_d   = sp_q;
    seg_en = ld_fire;
    sp_en  = ld_fire | dec_fire | inc_fire;
    if (ld_fire) begin
      seg_d = ld_seg;
      sp_d  = ld_sp;
    end else if (dec_fire) begin
      sp_d = sp_q - STEP_V;
    end else if (inc_fire) begin
      sp_d = sp_q + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else if (seg_en) begin
      seg_q <= seg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end
endmodule

// File: rtl/wstack_seq.sv
module wstack_seq
  import wstack_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             busy,
  output logic             ld_fire,
  output logic             dec_fire,
  output logic             inc_fire,
  output logic             wr_act,
  output logic             rd_act,
  output logic             cap_en,
  output logic [CNT_W-1:0] cap_lane,
  output logic             finish,
  output logic [CNT_W-1:0] lane
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    ld_fire  = 1'b0;
    dec_fire = 1'b0;
    inc_fire = 1'b0;
    wr_act   = 1'b0;
    rd_act   = 1'b0;
    cap_en   = 1'b0;
    finish   = 1'b0;
    cap_lane = cnt_q - ONE;
    unique case (state_q)
      ST_IDLE: begin
        // priority: load, then push, then pop (R11)
        if (ld_en) begin
          ld_fire = 1'b1;
        end else if (push_req) begin
          dec_fire = 1'b1;
          state_d  = ST_WR;
          cnt_d    = '0;
          cnt_en   = 1'b1;
        end else if (pop_req) begin
          state_d = ST_RD;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_WR: begin
        wr_act = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
        end
      end
      ST_RD: begin
        rd_act = 1'b1;
        cap_en = (cnt_q != '0);
        if (cnt_q == LAST) begin
          state_d = ST_RD_TAIL;
        end else begin
          cnt_d  = cnt_q + ONE;
          cnt_en = 1'b1;
        end
      end
      ST_RD_TAIL: begin
        finish   = 1'b1;
        inc_fire = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign lane = cnt_q;
endmodule

// File: rtl/wstack_lanes.sv
module wstack_lanes #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int CNT_W  = 1,
  parameter int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [WORD_W-1:0] push_word,
  input  logic [CNT_W-1:0]  lane,
  input  logic              cap_en,
  input  logic [CNT_W-1:0]  cap_lane,
  input  logic              finish,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] wbyte,
  output logic [WORD_W-1:0] pop_word,
  output logic              pop_valid
);
  logic [WORD_W-1:0] wr_buf_q;
  logic [BYTE_W-1:0] wr_lane [LANES];
  logic [BYTE_W-1:0] rd_lane_q [LANES-1];
  logic [WORD_W-1:0] pop_word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_buf_q <= '0;
    end else if (load_wr) begin
      wr_buf_q <= push_word;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_wr_lane
      assign wr_lane[g] = wr_buf_q[g*BYTE_W +: BYTE_W];
    end
    for (g = 0; g < LANES - 1; g++) begin : g_rd_lane
      logic cap_hit;
      assign cap_hit = cap_en && (cap_lane == CNT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_lane_q[g] <= '0;
        end else if (cap_hit) begin
          rd_lane_q[g] <= rdata;
        end
      end
      assign pop_word_d[g*BYTE_W +: BYTE_W] = rd_lane_q[g];
    end
  endgenerate

  // top lane comes straight from the memory in the tail cycle
  assign pop_word_d[WORD_W-1 -: BYTE_W] = rdata;
  assign wbyte = wr_lane[lane];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_word <= '0;
    end else if (finish) begin
      pop_word <= pop_word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= finish;
    end
  end
endmodule

// File: rtl/wstack_engine.sv
module wstack_engine #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [OFF_W-1:0]  ld_sp,
  input  logic              push_req,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop_req,
  output logic              busy,
  output logic [WORD_W-1:0] pop_word,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [SEG_W-1:0]  seg_o,
  output logic [OFF_W-1:0]  sp_o
);
  logic             ld_fire, dec_fire, inc_fire;
  logic             wr_act, rd_act, cap_en, finish;
  logic [CNT_W-1:0] cap_lane, lane;

  wstack_seq #(.LANES(LANES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .push_req(push_req), .pop_req(pop_req),
    .busy(busy), .ld_fire(ld_fire), .dec_fire(dec_fire), .inc_fire(inc_fire),
    .wr_act(wr_act), .rd_act(rd_act), .cap_en(cap_en), .cap_lane(cap_lane),
    .finish(finish), .lane(lane)
  );

  wstack_regs #(.SEG_W(SEG_W), .OFF_W(OFF_W), .STEP(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(ld_fire), .ld_seg(ld_seg), .ld_sp(ld_sp),
    .dec_fire(dec_fire), .inc_fire(inc_fire),
    .seg_q(seg_o), .sp_q(sp_o)
  );

  wstack_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .CNT_W(CNT_W),
                .ADDR_W(ADDR_W)) u_addr (
    .seg(seg_o), .off(sp_o), .lane(lane), .phys(mem_addr)
  );

  wstack_lanes #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W),
                 .WORD_W(WORD_W)) u_lanes (
    .clk(clk), .rst_n(rst_n),
    .load_wr(dec_fire), .push_word(push_word), .lane(lane),
    .cap_en(cap_en), .cap_lane(cap_lane), .finish(finish),
    .rdata(mem_rdata), .wbyte(mem_wdata),
    .pop_word(pop_word), .pop_valid(pop_valid)
  );

  assign mem_we = wr_act;
  assign mem_re = rd_act;
endmodule

// File: rtl/wstack_engine_chk.sv
module wstack_engine_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [SEG_W-1:0]  ld_seg,
  input logic [OFF_W-1:0]  ld_sp,
  input logic              push_req,
  input logic              pop_req,
  input logic              busy,
  input logic              pop_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [SEG_W-1:0]  seg_o,
  input logic [OFF_W-1:0]  sp_o
);
  localparam logic [OFF_W-1:0]  STEP_V = OFF_W'(LANES);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);

  // R2: idle load lands on the next edge
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_en) |=> (seg_o == $past(ld_seg) && sp_o == $past(ld_sp)));

  // R5: accepted push lowers the offset by one word
  p_push_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_en && push_req) |=> (sp_o == $past(sp_o) - STEP_V));

  // R6: offset rises by one word as the popped word is presented
  p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (sp_o == $past(sp_o) + STEP_V));

  // R4: never read and write together
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R4: consecutive byte accesses step the address by one
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ONE_A));
  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ONE_A));

  // R8: memory strobes only inside a busy window; base held while busy
  p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seg_o));

  // R12: valid strobe lasts one cycle and follows a busy cycle
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> !pop_valid);
  p_valid_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (!busy && $past(busy)));

  // R11: pop request alone never moves the offset at the accepting edge
  p_pop_no_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_en && !push_req && pop_req) |=> $stable(sp_o));
endmodule

bind wstack_engine wstack_engine_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .LANES(LANES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_seg(ld_seg), .ld_sp(ld_sp),
  .push_req(push_req), .pop_req(pop_req), .busy(busy), .pop_valid(pop_valid),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .seg_o(seg_o), .sp_o(sp_o)
);

// File: tb/test_wstack_engine.sv
module test_wstack_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, push_req, pop_req;
  logic [15:0] ld_seg, ld_sp, push_word;
  logic        busy, pop_valid, mem_we, mem_re;
  logic [15:0] pop_word, seg_o, sp_o;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  wstack_engine i_wstack_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_seg(ld_seg), .ld_sp(ld_sp),
    .push_req(push_req), .push_word(push_word), .pop_req(pop_req),
    .busy(busy), .pop_word(pop_word), .pop_valid(pop_valid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .seg_o(seg_o), .sp_o(sp_o)
  );

  // byte memory model: write on edge, read data one cycle later
  logic [7:0] ram [logic [19:0]];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of stack state
  logic [15:0] mseg, msp;
  logic [15:0] model_stk [$];
  logic [15:0] exp_q [$];

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    phys = 20'({s, 4'h0}) + 20'(o);
  endfunction

  function automatic logic [7:0] rd_ram(input logic [19:0] a);
    rd_ram = ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  // monitor: scoreboard compare and pulse-width check
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_valid) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected pop_valid", 32'(pop_word), 32'hFFFF_FFFF);
        end else begin
          chk("R7 popped word order", 32'(pop_word), 32'(exp_q.pop_front()));
        end
        chk("R12 pop_valid single cycle", 32'(prev_valid), 32'd0);
      end
      prev_valid <= pop_valid;
    end
  end

  task automatic do_load(input logic [15:0] s, input logic [15:0] p);
    ld_en = 1'b1; ld_seg = s; ld_sp = p;
    @(negedge clk);
    ld_en = 1'b0;
    mseg = s; msp = p;
    chk("R2 base loaded", 32'(seg_o), 32'(s));
    chk("R2 offset loaded", 32'(sp_o), 32'(p));
  endtask

  task automatic do_push(input logic [15:0] w);
    int bcy;
    logic [19:0] a;
    push_req = 1'b1; push_word = w;
    @(negedge clk);
    push_req = 1'b0;
    msp = msp - 16'd2;
    a = phys(mseg, msp);
    bcy = 0;
    while (busy) begin
      if (bcy == 0) begin
        chk("R3 low byte address", 32'(mem_addr), 32'(a));
        chk("R4 low byte first", 32'(mem_wdata), 32'(w[7:0]));
      end
      chk("R12 mem_we through push", 32'(mem_we), 32'd1);
      bcy++;
      @(negedge clk);
    end
    chk("R12 push busy cycles", 32'(bcy), 32'd2);
    chk("R5 offset lowered by 2", 32'(sp_o), 32'(msp));
    chk("R4 low byte at A", 32'(rd_ram(a)), 32'(w[7:0]));
    chk("R4 high byte at A+1", 32'(rd_ram(a + 20'd1)), 32'(w[15:8]));
    model_stk.push_back(w);
  endtask

  task automatic do_pop();
    int bcy;
    exp_q.push_back(model_stk.pop_back());
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    bcy = 0;
    while (busy) begin
      if (bcy == 0) chk("R6 read at current offset", 32'(mem_addr), 32'(phys(mseg, msp)));
      bcy++;
      @(negedge clk);
    end
    msp = msp + 16'd2;
    chk("R12 pop busy cycles", 32'(bcy), 32'd3);
    chk("R12 pop_valid after busy", 32'(pop_valid), 32'd1);
    chk("R6 offset raised by 2", 32'(sp_o), 32'(msp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    ld_seg = '0; ld_sp = '0; push_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 seg_o in reset", 32'(seg_o), 32'd0);
    chk("R1 sp_o in reset", 32'(sp_o), 32'd0);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 strobes in reset", 32'({mem_we, mem_re, pop_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mseg = 16'h0000; msp = 16'h0000;

    // R2 R3 R5 R7: region 58A10h..58B0Fh
    do_load(16'h58A1, 16'h0100);
    do_push(16'h1234);
    chk("R3 first word low byte at 58B0E", 32'(rd_ram(20'h58B0E)), 32'h34);
    do_push(16'h5678);
    chk("R3 second word low byte at 58B0C", 32'(rd_ram(20'h58B0C)), 32'h78);
    do_pop();
    do_pop();
    chk("R7 empty offset restored", 32'(sp_o), 32'h0100);

    // R8: requests held through a busy window are ignored
    push_req = 1'b1; push_word = 16'hA1B2;
    @(negedge clk);
    push_word = 16'hC3D4; pop_req = 1'b1; ld_en = 1'b1;
    ld_seg = 16'h1111; ld_sp = 16'h2222;
    while (busy) @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0; ld_en = 1'b0;
    msp = msp - 16'd2;
    model_stk.push_back(16'hA1B2);
    chk("R8 base unchanged", 32'(seg_o), 32'(mseg));
    chk("R8 offset moved once", 32'(sp_o), 32'(msp));
    chk("R8 word sampled at accept", 32'({rd_ram(phys(mseg, msp) + 20'd1), rd_ram(phys(mseg, msp))}), 32'hA1B2);
    @(negedge clk);
    chk("R8 no late acceptance", 32'(busy), 32'd0);
    do_pop();

    // R11: load beats push beats pop
    ld_en = 1'b1; ld_seg = 16'h0040; ld_sp = 16'h0800; push_req = 1'b1; pop_req = 1'b1;
    push_word = 16'hDEAD;
    @(negedge clk);
    ld_en = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    mseg = 16'h0040; msp = 16'h0800;
    chk("R11 load wins, idle after", 32'({busy, mem_we}), 32'd0);
    chk("R11 load wins, offset", 32'(sp_o), 32'h0800);
    push_req = 1'b1; pop_req = 1'b1; push_word = 16'hBEEF;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    chk("R11 push beats pop", 32'(mem_we), 32'd1);
    while (busy) @(negedge clk);
    msp = msp - 16'd2;
    model_stk.push_back(16'hBEEF);
    chk("R11 push beats pop offset", 32'(sp_o), 32'(msp));
    do_pop();

    // R9: offset wrap
    do_load(16'h0300, 16'h0000);
    do_push(16'h0F1E);
    chk("R9 offset wraps to FFFE", 32'(sp_o), 32'hFFFE);
    do_pop();
    chk("R9 offset wraps back to 0", 32'(sp_o), 32'h0000);

    // R10: address wrap
    do_load(16'hFFFF, 16'h0020);
    do_push(16'h9ABC);
    chk("R10 low byte at 0000E", 32'(rd_ram(20'h0000E)), 32'hBC);
    chk("R10 high byte at 0000F", 32'(rd_ram(20'h0000F)), 32'h9A);
    do_pop();

    // R7: deeper sequence
    do_load(16'h2000, 16'h0040);
    for (int i = 0; i < 6; i++) do_push(16'(16'h1100 + i * 16'h0111));
    for (int i = 0; i < 6; i++) do_pop();
    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule